// File: doc/BRIEF.md
# Memory Controller Interrupt Aggregator

This block merges four event sources of an external memory controller into one interrupt request line. Two of the sources are asynchronous wait pins. Each pin is brought into the clock domain and watched for one edge direction, chosen per pin by a polarity input. The other two sources are level conditions from a prefetch engine: the remaining-request count having reached zero, and a FIFO level being available.

Every source owns one bit in a status register and the bit at the same position in an enable register. Pin edges are captured sticky and are cleared by writing one to their status bit. Level events mirror their condition, one cycle late, so a clear write does nothing while the condition holds. The FIFO event is forced off while the prefetch engine is in DMA mode. The interrupt output is a registered OR over all status bits that are also enabled.

A simple register port is used by software. Reads are combinational from the selected address. A write takes effect on the next rising clock edge.

Top module: `mc_irq_agg`

## Requirements
- R1: While reset is asserted and right after it is released, the status and enable registers read zero and the interrupt output is low.
- R2: A wait pin sets its status bit (bit 8 for pin 0, bit 9 for pin 1) on a rising edge when its polarity input is 1 and on a falling edge when it is 0. The opposite edge sets nothing. The bit reads set after the third rising clock edge following the pin change, and not after the second.
- R3: A set wait-pin status bit stays set until a write to the status address carries a 1 in that bit position. Writing 0 to that bit, or 1 to the other wait bit, leaves it set.
- R4: If a wait-pin edge is captured on the same clock edge as a clear write to that bit, the bit ends up set.
- R5: Status bit 1 equals the terminal-count level sampled on the previous clock edge. Writing 1 to it has no effect while the level is high.
- R6: Status bit 0 equals the FIFO level sampled on the previous clock edge while the DMA-mode input is 0, and reads 0 while the DMA-mode input is 1.
- R7: The enable register stores bits 0, 1, 8 and 9 when written at the enable address. All its other bits read zero.
- R8: The interrupt output goes high one clock edge after any status bit and its matching enable bit are both set, and low one edge after no such pair remains.
- R9: The status register is at address 0 and the enable register is at address 1. Any other address reads zero, and writes to it change neither register. Status bits other than 0, 1, 8 and 9 read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wait_pin | input | 2 | Asynchronous wait pins, index 0 and 1 |
| wait_rise | input | 2 | Per-pin edge select: 1 = rising, 0 = falling |
| tc_level | input | 1 | Prefetch remaining-request count is zero |
| fifo_level | input | 1 | Prefetch FIFO level available |
| dma_mode | input | 1 | Prefetch engine in DMA mode; masks the FIFO event |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr |
| irq | output | 1 | Shared interrupt request |

## Verification
The level-event assertions assume that the terminal-count, FIFO and DMA-mode inputs are synchronous to the clock and held low through reset. Otherwise, the first sample after reset could disagree with a mirror that is still being cleared. The pin checks assume each wait pin stays still for several cycles before a measured edge. The stimulus therefore parks every pin, lets the synchronizer settle, and clears the status bits before it toggles the pin under test. All inputs change only on falling clock edges.

// File: rtl/mc_irq_pkg.sv
package mc_irq_pkg;
   localparam int unsigned EVT_N = 4;
   localparam int unsigned IDX_FIFO = 0;
   localparam int unsigned IDX_TC   = 1;
   localparam int unsigned IDX_W0   = 2;
   localparam int unsigned IDX_W1   = 3;
   // register bit position for each compact event index
   localparam int unsigned EVT_POS [EVT_N] = '{0, 1, 8, 9};
   localparam int unsigned POS_MAX = 9;
   // compact indices captured sticky (pin edges); the rest mirror a level
   localparam logic [EVT_N-1:0] STICKY_MASK = 4'b1100;
   localparam int unsigned WAIT_N = 2;
endpackage

// File: rtl/mc_irq_edge.sv
module mc_irq_edge #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic rise_sel,
   output logic pulse
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("mc_irq_edge: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   last_q;
   logic                   cur;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
         last_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign cur   = sync_q[SYNC_STAGES-1];
   assign pulse = rise_sel ? (cur & ~last_q) : (~cur & last_q);
endmodule

// File: rtl/mc_irq_bank.sv
module mc_irq_bank #(
   parameter int unsigned           N      = 4,
   parameter logic [N-1:0]          STICKY = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] evt,
   input  logic [N-1:0] clr,
   input  logic         en_we,
   input  logic [N-1:0] en_d,
   output logic [N-1:0] stat_q,
   output logic [N-1:0] en_q,
   output logic         irq_q
);
   generate
      if (N < 1) begin : g_bad_n
         $error("mc_irq_bank: N must be at least 1");
      end
   endgenerate

   for (genvar i = 0; i < N; i++) begin : g_bit
      if (STICKY[i]) begin : g_sticky
         // new edge has priority over a clear in the same cycle
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stat_q[i] <= 1'b0;
            else        stat_q[i] <= evt[i] | (stat_q[i] & ~clr[i]);
         end
      end else begin : g_level
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stat_q[i] <= 1'b0;
            else        stat_q[i] <= evt[i];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         irq_q <= 1'b0;
      end else begin
         if (en_we) en_q <= en_d;
         irq_q <= |(stat_q & en_q);
      end
   end
endmodule

// File: rtl/mc_irq_agg.sv
module mc_irq_agg
   import mc_irq_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned STAT_ADDR   = 0,
   parameter int unsigned EN_ADDR     = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        wait_pin,
   input  logic [1:0]        wait_rise,
   input  logic              tc_level,
   input  logic              fifo_level,
   input  logic              dma_mode,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq
);
   localparam int unsigned ADDR_SPAN = 1 << ADDR_W;

   generate
      if (DATA_W <= POS_MAX) begin : g_bad_width
         $error("mc_irq_agg: DATA_W too narrow for event bit positions");
      end
      if (STAT_ADDR == EN_ADDR) begin : g_bad_map
         $error("mc_irq_agg: status and enable addresses collide");
      end
      if (STAT_ADDR >= ADDR_SPAN || EN_ADDR >= ADDR_SPAN) begin : g_bad_addr
         $error("mc_irq_agg: register address outside ADDR_W range");
      end
   endgenerate

   logic [WAIT_N-1:0] edge_pulse;
   logic [EVT_N-1:0]  evt_in;
   logic [EVT_N-1:0]  wr_bits;
   logic [EVT_N-1:0]  clr_bits;
   logic [EVT_N-1:0]  stat_q;
   logic [EVT_N-1:0]  en_q;
   logic              sel_stat;
   logic              sel_en;
   logic              en_we;

   for (genvar p = 0; p < WAIT_N; p++) begin : g_wait
      mc_irq_edge #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .pin      (wait_pin[p]),
         .rise_sel (wait_rise[p]),
         .pulse    (edge_pulse[p])
      );
   end

   assign evt_in[IDX_FIFO] = fifo_level & ~dma_mode;
   assign evt_in[IDX_TC]   = tc_level;
   assign evt_in[IDX_W0]   = edge_pulse[0];
   assign evt_in[IDX_W1]   = edge_pulse[1];

   assign sel_stat = (reg_addr == ADDR_W'(STAT_ADDR));
   assign sel_en   = (reg_addr == ADDR_W'(EN_ADDR));
   assign en_we    = reg_wr & sel_en;

   for (genvar i = 0; i < EVT_N; i++) begin : g_pick
      assign wr_bits[i] = reg_wdata[EVT_POS[i]];
   end
   assign clr_bits = (reg_wr & sel_stat) ? wr_bits : '0;

   mc_irq_bank #(.N(EVT_N), .STICKY(STICKY_MASK)) bank_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt    (evt_in),
      .clr    (clr_bits),
      .en_we  (en_we),
      .en_d   (wr_bits),
      .stat_q (stat_q),
      .en_q   (en_q),
      .irq_q  (irq)
   );

   always_comb begin
      reg_rdata = '0;
      for (int i = 0; i < EVT_N; i++) begin
         if (sel_stat)    reg_rdata[EVT_POS[i]] = stat_q[i];
         else if (sel_en) reg_rdata[EVT_POS[i]] = en_q[i];
      end
   end
endmodule

// File: rtl/mc_irq_agg_chk.sv
module mc_irq_agg_chk
   import mc_irq_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 2,
   parameter int unsigned STAT_ADDR = 0,
   parameter int unsigned EN_ADDR = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tc_level,
   input logic              fifo_level,
   input logic              dma_mode,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              reg_wr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [DATA_W-1:0] reg_rdata,
   input logic              irq,
   input logic [EVT_N-1:0]  stat_q,
   input logic [EVT_N-1:0]  en_q
);
   function automatic logic [DATA_W-1:0] used_mask();
      logic [DATA_W-1:0] m = '0;
      for (int i = 0; i < EVT_N; i++) m[EVT_POS[i]] = 1'b1;
      return m;
   endfunction
   localparam logic [DATA_W-1:0] USED = used_mask();

   logic stat_wr;
   assign stat_wr = reg_wr && (reg_addr == ADDR_W'(STAT_ADDR));

   p_tc_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tc_level |=> stat_q[IDX_TC]);
   p_tc_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !tc_level |=> !stat_q[IDX_TC]);
   p_fifo_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_level && !dma_mode) |=> stat_q[IDX_FIFO]);
   p_fifo_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      dma_mode |=> !stat_q[IDX_FIFO]);
   p_w0_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[IDX_W0] && !(stat_wr && reg_wdata[EVT_POS[IDX_W0]])) |=> stat_q[IDX_W0]);
   p_w1_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[IDX_W1] && !(stat_wr && reg_wdata[EVT_POS[IDX_W1]])) |=> stat_q[IDX_W1]);
   p_irq_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|(stat_q & en_q)) |=> irq);
   p_irq_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(stat_q & en_q)) |=> !irq);
   p_unused_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata & ~USED) == '0);
   p_en_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && reg_addr == ADDR_W'(EN_ADDR)) |=> $stable(en_q));
endmodule

bind mc_irq_agg mc_irq_agg_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .EN_ADDR(EN_ADDR)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .tc_level   (tc_level),
   .fifo_level (fifo_level),
   .dma_mode   (dma_mode),
   .reg_addr   (reg_addr),
   .reg_wr     (reg_wr),
   .reg_wdata  (reg_wdata),
   .reg_rdata  (reg_rdata),
   .irq        (irq),
   .stat_q     (stat_q),
   .en_q       (en_q)
);

// File: tb/mc_irq_agg_tb_top.sv
`timescale 1ns/1ps
module mc_irq_agg_tb_top;
   localparam int DW = 32;
   localparam int AW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    wait_pin = '0;
   logic [1:0]    wait_rise = '0;
   logic          tc_level = 1'b0;
   logic          fifo_level = 1'b0;
   logic          dma_mode = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic          reg_wr = 1'b0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          irq;

   int total = 0;
   int fails = 0;

   always #2.5 clk = ~clk;

   mc_irq_agg dut_i (
      .clk(clk), .rst_n(rst_n), .wait_pin(wait_pin), .wait_rise(wait_rise),
      .tc_level(tc_level), .fifo_level(fifo_level), .dma_mode(dma_mode),
      .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq(irq)
   );

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   function automatic logic [DW-1:0] widen(input logic [3:0] c);
      logic [DW-1:0] w = '0;
      w[0] = c[0]; w[1] = c[1]; w[8] = c[2]; w[9] = c[3];
      return w;
   endfunction

   task automatic summary();
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   endtask

   initial begin
      #1_000_000;
      total++; fails++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      logic [DW-1:0] v;
      logic [DW-1:0] exp_bit;
      tick(3);
      // R1 during reset
      rd(0, v); chk("R1 status in reset", v, '0);
      rd(1, v); chk("R1 enable in reset", v, '0);
      chk("R1 irq in reset", {31'b0, irq}, '0);
      rst_n = 1'b1;
      tick(2);
      rd(0, v); chk("R1 status after reset", v, '0);
      chk("R1 irq after reset", {31'b0, irq}, '0);

      // R2 sweep: pin x polarity x edge direction
      for (int p = 0; p < 2; p++) begin
         for (int pol = 0; pol < 2; pol++) begin
            for (int rise = 0; rise < 2; rise++) begin
               wait_rise[p] = pol[0];
               wait_pin[p]  = ~rise[0];
               tick(5);
               wr(0, 32'h300);
               wait_pin[p] = rise[0];
               tick(2);
               rd(0, v); chk("R2 not before third edge", v & 32'h300, '0);
               tick(1);
               exp_bit = '0;
               if (rise == pol) exp_bit[8 + p] = 1'b1;
               rd(0, v); chk("R2 edge polarity", v & 32'h300, exp_bit);
            end
         end
      end

      // R3 stickiness of bit 8
      wait_rise = 2'b11; wait_pin = 2'b00;
      tick(5); wr(0, 32'h300);
      wait_pin[0] = 1'b1; tick(3);
      rd(0, v); chk("R3 set", v & 32'h300, 32'h100);
      wr(0, 32'h0);   rd(0, v); chk("R3 write zero keeps", v & 32'h300, 32'h100);
      wr(0, 32'h200); rd(0, v); chk("R3 other bit clear keeps", v & 32'h300, 32'h100);
      tick(4);        rd(0, v); chk("R3 held", v & 32'h300, 32'h100);
      wr(0, 32'h100); rd(0, v); chk("R3 w1c clears", v & 32'h300, 32'h0);

      // R4 set wins over simultaneous clear
      wait_pin[0] = 1'b0; tick(5);
      wait_pin[0] = 1'b1; tick(5);
      rd(0, v); chk("R4 preset", v & 32'h300, 32'h100);
      wait_pin[0] = 1'b0; tick(5);
      wait_pin[0] = 1'b1; tick(2);
      wr(0, 32'h100);
      rd(0, v); chk("R4 set beats clear", v & 32'h300, 32'h100);

      // R5 terminal count level
      tc_level = 1'b1; tick(1);
      rd(0, v); chk("R5 tc follows high", v & 32'h2, 32'h2);
      wr(0, 32'h2); rd(0, v); chk("R5 clear ignored while high", v & 32'h2, 32'h2);
      tc_level = 1'b0; tick(1);
      rd(0, v); chk("R5 tc follows low", v & 32'h2, 32'h0);

      // R6 FIFO level with DMA gating, all four combinations
      for (int k = 0; k < 4; k++) begin
         fifo_level = k[0]; dma_mode = k[1];
         tick(1);
         rd(0, v);
         chk("R6 fifo gating", v & 32'h1, {31'b0, k[0] & ~k[1]});
      end
      fifo_level = 1'b0; dma_mode = 1'b0;

      // R7 enable: all ones maps to used bits only
      wr(1, 32'hFFFF_FFFF); rd(1, v); chk("R7 enable used bits", v, 32'h303);

      // R8/R7 sweep: status = tc (1) and wait0 (8); enables all 16 patterns
      tc_level = 1'b1; tick(2);
      rd(0, v); chk("R8 status pattern", v, 32'h102);
      for (int e = 0; e < 16; e++) begin
         wr(1, widen(e[3:0]));
         rd(1, v); chk("R7 enable readback", v, widen(e[3:0]));
         tick(1);
         chk("R8 irq", {31'b0, irq}, {31'b0, (e[1] | e[2])});
      end
      // R8 irq drops one edge after the pair is gone
      wr(1, 32'h2); tick(1);
      chk("R8 irq high", {31'b0, irq}, 32'h1);
      tc_level = 1'b0; tick(1);
      chk("R8 irq still high", {31'b0, irq}, 32'h1);
      tick(1);
      chk("R8 irq low", {31'b0, irq}, 32'h0);

      // R9 unmapped addresses and unused status bits
      wr(1, 32'h101);
      wr(2, 32'hFFFF_FFFF); wr(3, 32'hFFFF_FFFF);
      rd(2, v); chk("R9 addr 2 reads zero", v, '0);
      rd(3, v); chk("R9 addr 3 reads zero", v, '0);
      rd(1, v); chk("R9 enable untouched", v, 32'h101);
      rd(0, v); chk("R9 status untouched", v, 32'h100);
      wr(0, 32'hFFFF_FCFC);
      rd(0, v); chk("R9 unused status bits", v, 32'h100);

      summary();
   end
endmodule